// File: doc/BRIEF.md
# Frame-Aligned DMA Suspend Sequencer

This block controls how one direction of a packet DMA channel is put to sleep. A suspend request does not cut into a frame on the wire. The block waits until the MAC side reaches a frame boundary and then stops it. After that it lets the host-side DMA run on. In receive mode the DMA empties the FIFO into host memory. In transmit mode it fills the FIFO from host memory. It runs until that FIFO work is complete or no descriptors remain. Only then does it halt descriptor polling, raise a suspended status and set a sticky suspend-interrupt flag.

The parameter `IS_RX` chooses the direction. A value of 1 selects receive, where the stop condition is an empty FIFO. A value of 0 selects transmit, where the stop condition is a full FIFO. Dropping `runEn` is the hard stop: the MAC and descriptor processing halt at once, even in the middle of a frame, and any pending suspend request is discarded. The FIFO storage and the DMA datapath live outside this block.

Top module: `dma_suspend_seq`

## Requirements
- R1: While `rstN` is low, `suspended`, `suspIntFlag` and `irq` are 0 and the sequencer is idle. An idle sequencer with `runEn`=1 drives `macStop`=0, `dmaAllow`=1 and `pollEn`=1.
- R2: A request accepted while `frameActive`=1 keeps `macStop` at 0 for as long as `frameActive` stays 1. `macStop` rises on the first clock edge at which `frameActive` is 0.
- R3: A request seen at a clock edge while `runEn`=1 and `frameActive`=0 brings `macStop` to 1 after that single edge, with no frame-wait phase.
- R4: When `IS_RX`=1 and the MAC is stopped, the drain phase ends at the first clock edge at which `fifoEmpty`=1 or `descAvail`=0.
- R5: When `IS_RX`=0 and the MAC is stopped, the drain phase ends at the first clock edge at which `fifoFull`=1 or `descAvail`=0.
- R6: At the edge that ends the drain phase, `suspended` goes to 1 and `suspIntFlag` is set. While suspended, `pollEn`=0 and `dmaAllow`=0.
- R7: `irq` is 1 exactly when `suspIntFlag`, `suspIntEn` and `intrEn` are all 1.
- R8: `suspIntFlag` stays at 1 until a clock edge with `suspIntClr`=1. A set in the same cycle as a clear wins.
- R9: With `runEn`=0, `macStop` is 1 and `dmaAllow` and `pollEn` are 0 in the same cycle. The next edge returns the sequencer to idle. A request that was high while `runEn` was 0 is ignored until `suspReq` has been 0 for at least one edge.
- R10: Dropping `suspReq` while suspended clears `suspended` at the next edge and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Channel run enable |
| suspReq | input | 1 | Suspend request level |
| frameActive | input | 1 | MAC is inside a frame |
| fifoEmpty | input | 1 | FIFO empty (stop condition for receive) |
| fifoFull | input | 1 | FIFO full (stop condition for transmit) |
| descAvail | input | 1 | At least one descriptor is available |
| intrEn | input | 1 | Global interrupt enable |
| suspIntEn | input | 1 | Suspend interrupt enable |
| suspIntClr | input | 1 | Write-one-to-clear strobe for the flag |
| macStop | output | 1 | Hold the MAC side stopped |
| dmaAllow | output | 1 | Host-side DMA may transfer |
| pollEn | output | 1 | Descriptor polling enabled |
| suspended | output | 1 | Suspended status |
| suspIntFlag | output | 1 | Sticky suspend-interrupt flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `IS_RX`=1 and the other `IS_RX`=0. This places the empty-FIFO and full-FIFO stop conditions in one run, so a mix-up between them is visible at the ports. Both copies are compared every cycle against a bench model. Random run drops and request withdrawals reach the abort paths out of every state.

// File: rtl/dma_suspend_pkg.sv
package dma_suspend_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_EOF  = 2'd1,
    ST_DRAIN     = 2'd2,
    ST_SUSPENDED = 2'd3
  } suspState_e;

  typedef struct packed {
    logic setSusp;
    logic clrSusp;
  } suspStrobe_t;
endpackage

// File: rtl/dma_suspend_ctrl.sv
module dma_suspend_ctrl
  import dma_suspend_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        suspReq,
  input  logic        frameActive,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  input  logic        descAvail,
  output logic        macStop,
  output logic        dmaAllow,
  output logic        pollEn,
  output suspStrobe_t strobe
);
  suspState_e stateQ, stateD;
  logic       killQ;
  logic       reqEff;
  logic       fifoDone;
  logic       stopCond;

  generate
    if (IS_RX) begin : g_rx
      assign fifoDone = fifoEmpty;
    end else begin : g_tx
      assign fifoDone = fifoFull;
    end
  endgenerate

  assign stopCond = fifoDone || !descAvail;
  assign reqEff   = suspReq && runEn && !killQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (!reqEff) begin
      stateD = ST_IDLE;
      strobe.clrSusp = (stateQ == ST_SUSPENDED);
    end else begin
      unique case (stateQ)
        ST_IDLE:     stateD = frameActive ? ST_WAIT_EOF : ST_DRAIN;
        ST_WAIT_EOF: if (!frameActive) stateD = ST_DRAIN;
        ST_DRAIN: if (stopCond) begin
          stateD = ST_SUSPENDED;
          strobe.setSusp = 1'b1;
        end
        default:     stateD = ST_SUSPENDED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      killQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (!suspReq)    killQ <= 1'b0;
      else if (!runEn) killQ <= 1'b1;
    end
  end

  assign macStop  = !runEn || (stateQ == ST_DRAIN) || (stateQ == ST_SUSPENDED);
  assign dmaAllow = runEn && (stateQ != ST_SUSPENDED);
  assign pollEn   = runEn && (stateQ != ST_SUSPENDED);

  // R3
  skip_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && reqEff && !frameActive) |=> stateQ == ST_DRAIN);
  // R2
  hold_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_EOF && reqEff && frameActive) |=> stateQ == ST_WAIT_EOF);
  // R9
  run_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> stateQ == ST_IDLE);
  // R6
  drain_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRAIN && reqEff && stopCond) |=> stateQ == ST_SUSPENDED);
endmodule

// File: rtl/dma_suspend_dp.sv
module dma_suspend_dp
  import dma_suspend_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  suspStrobe_t strobe,
  input  logic        suspIntClr,
  input  logic        intrEn,
  input  logic        suspIntEn,
  output logic        suspended,
  output logic        suspIntFlag,
  output logic        irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspended   <= 1'b0;
      suspIntFlag <= 1'b0;
    end else begin
      if (strobe.setSusp)      suspended <= 1'b1;
      else if (strobe.clrSusp) suspended <= 1'b0;
      if (strobe.setSusp)      suspIntFlag <= 1'b1;
      else if (suspIntClr)     suspIntFlag <= 1'b0;
    end
  end

  assign irq = suspIntFlag && suspIntEn && intrEn;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (suspIntFlag && !suspIntClr) |=> suspIntFlag);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setSusp |=> suspIntFlag);
  // R10
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrSusp |=> !suspended);
endmodule

// File: rtl/dma_suspend_seq.sv
module dma_suspend_seq
  import dma_suspend_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic suspReq,
  input  logic frameActive,
  input  logic fifoEmpty,
  input  logic fifoFull,
  input  logic descAvail,
  input  logic intrEn,
  input  logic suspIntEn,
  input  logic suspIntClr,
  output logic macStop,
  output logic dmaAllow,
  output logic pollEn,
  output logic suspended,
  output logic suspIntFlag,
  output logic irq
);
  suspStrobe_t strobe;

  dma_suspend_ctrl #(.IS_RX(IS_RX)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .suspReq(suspReq),
    .frameActive(frameActive), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .descAvail(descAvail), .macStop(macStop), .dmaAllow(dmaAllow),
    .pollEn(pollEn), .strobe(strobe)
  );

  dma_suspend_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .suspIntClr(suspIntClr),
    .intrEn(intrEn), .suspIntEn(suspIntEn), .suspended(suspended),
    .suspIntFlag(suspIntFlag), .irq(irq)
  );

  // R6
  no_poll_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> (!pollEn && !dmaAllow && macStop));
  // R9
  run_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (macStop && !dmaAllow && !pollEn));
endmodule

// File: tb/dma_suspend_seq_bench.sv
module dma_suspend_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, suspReq = 0, frameActive = 0, fifoEmpty = 0, fifoFull = 0;
  logic descAvail = 1, intrEn = 0, suspIntEn = 0, suspIntClr = 0;
  logic [1:0] macStop, dmaAllow, pollEn, suspended, suspIntFlag, irq;
  int checks = 0;
  int fails = 0;

  // model state per copy: index 0 = receive, 1 = transmit
  int  mState [2];
  bit  mKill  [2];
  bit  mFlag  [2];

  always #10 clk = ~clk;

  dma_suspend_seq #(.IS_RX(1'b1)) u_dma_suspend_seq (
    .clk(clk), .rstN(rstN), .runEn(runEn), .suspReq(suspReq),
    .frameActive(frameActive), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .descAvail(descAvail), .intrEn(intrEn), .suspIntEn(suspIntEn),
    .suspIntClr(suspIntClr), .macStop(macStop[0]), .dmaAllow(dmaAllow[0]),
    .pollEn(pollEn[0]), .suspended(suspended[0]),
    .suspIntFlag(suspIntFlag[0]), .irq(irq[0]));

  dma_suspend_seq #(.IS_RX(1'b0)) u_dma_suspend_seq_tx (
    .clk(clk), .rstN(rstN), .runEn(runEn), .suspReq(suspReq),
    .frameActive(frameActive), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .descAvail(descAvail), .intrEn(intrEn), .suspIntEn(suspIntEn),
    .suspIntClr(suspIntClr), .macStop(macStop[1]), .dmaAllow(dmaAllow[1]),
    .pollEn(pollEn[1]), .suspended(suspended[1]),
    .suspIntFlag(suspIntFlag[1]), .irq(irq[1]));

  // 0 idle, 1 wait frame end, 2 drain, 3 suspended
  function automatic bit expStop(int i);
    bit fifoDone = (i == 0) ? fifoEmpty : fifoFull;
    return fifoDone || !descAvail;
  endfunction

  function automatic bit expMacStop(int i);
    return !runEn || mState[i] >= 2;
  endfunction

  function automatic bit expAllow(int i);
    return runEn && mState[i] != 3;
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    for (int i = 0; i < 2; i++) begin
      check(macStop[i],     expMacStop(i),        "R2", "macStop");
      check(dmaAllow[i],    expAllow(i),          "R9", "dmaAllow");
      check(pollEn[i],      expAllow(i),          "R6", "pollEn");
      check(suspended[i],   mState[i] == 3,       "R10", "suspended");
      check(suspIntFlag[i], mFlag[i],             "R8", "suspIntFlag");
      check(irq[i],         mFlag[i] && suspIntEn && intrEn, "R7", "irq");
    end
  endtask

  // one clock: model update from current inputs, then compare at negedge
  task automatic tick();
    int nS [2];
    bit nK [2];
    bit nF [2];
    for (int i = 0; i < 2; i++) begin
      bit req = suspReq && runEn && !mKill[i];
      bit setS = 0;
      nS[i] = mState[i];
      if (!req) nS[i] = 0;
      else case (mState[i])
        0: nS[i] = frameActive ? 1 : 2;
        1: if (!frameActive) nS[i] = 2;
        2: if (expStop(i)) begin nS[i] = 3; setS = 1; end
        default: nS[i] = 3;
      endcase
      nK[i] = !suspReq ? 1'b0 : (!runEn ? 1'b1 : mKill[i]);
      nF[i] = setS ? 1'b1 : (suspIntClr ? 1'b0 : mFlag[i]);
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      mState[i] = nS[i]; mKill[i] = nK[i]; mFlag[i] = nF[i];
    end
    @(negedge clk);
    checkAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mState[i] = 0; mKill[i] = 0; mFlag[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 2; i++) begin
      check(suspended[i], 1'b0, "R1", "suspended in reset");
      check(suspIntFlag[i], 1'b0, "R1", "flag in reset");
      check(irq[i], 1'b0, "R1", "irq in reset");
    end
    rstN = 1'b1;
    runEn = 1'b1;
    tick();
    check(pollEn[0] && dmaAllow[0] && !macStop[0], 1'b1, "R1", "idle running outputs");

    // R3 request with no frame: drain after one edge
    fifoEmpty = 0; fifoFull = 0; descAvail = 1; intrEn = 1; suspIntEn = 1;
    suspReq = 1;
    tick();
    check(macStop[0], 1'b1, "R3", "rx stopped after one edge");
    check(macStop[1], 1'b1, "R3", "tx stopped after one edge");
    // R4 / R5 direction-specific stop conditions
    fifoEmpty = 1;
    tick();
    check(suspended[0], 1'b1, "R4", "rx suspends on empty");
    check(suspended[1], 1'b0, "R5", "tx ignores empty");
    check(irq[0], 1'b1, "R7", "rx irq raised");
    fifoEmpty = 0; fifoFull = 1;
    tick();
    check(suspended[1], 1'b1, "R5", "tx suspends on full");
    fifoFull = 0;
    // R10 withdraw request
    suspReq = 0;
    tick();
    check(suspended[0] || suspended[1], 1'b0, "R10", "resumed");
    check(suspIntFlag[0], 1'b1, "R8", "flag still sticky");
    suspIntClr = 1;
    tick();
    suspIntClr = 0;
    check(suspIntFlag[0], 1'b0, "R8", "flag cleared");

    // R2 request during a frame
    frameActive = 1; suspReq = 1;
    repeat (4) tick();
    check(macStop[0], 1'b0, "R2", "mac runs through frame");
    frameActive = 0;
    tick();
    check(macStop[0], 1'b1, "R2", "mac stops at frame boundary");
    // R9 run drop mid-drain, then request ignored until dropped
    runEn = 0;
    #1 check(macStop[0] && !pollEn[0], 1'b1, "R9", "immediate stop");
    tick();
    runEn = 1;
    repeat (2) tick();
    check(macStop[0], 1'b0, "R9", "stale request ignored");
    suspReq = 0;
    tick();

    // randomized phase
    void'($urandom(32'h5A17));
    for (int n = 0; n < 4000; n++) begin
      runEn       = ($urandom % 40) != 0;
      if (($urandom % 12) == 0) suspReq = ~suspReq;
      if (($urandom % 5) == 0) frameActive = ~frameActive;
      fifoEmpty   = ($urandom % 4) == 0;
      fifoFull    = ($urandom % 4) == 0;
      descAvail   = ($urandom % 8) != 0;
      intrEn      = ($urandom % 3) != 0;
      suspIntEn   = ($urandom % 3) != 0;
      suspIntClr  = ($urandom % 10) == 0;
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule